// File: doc/BRIEF.md
# Circular Queue Pointer Status Tracker

This block keeps the two pointers of one circular message queue whose entries live in external memory. The producer inserts at the head pointer and the consumer removes at the tail pointer. One of the two sides is a hardware agent and the other is software. The parameter `QKIND` picks one of four queue variants, and the variant fixes which side owns which pointer and which interrupt the block raises. Software can load either pointer through its own write port. The hardware agent moves only the pointer it owns, one entry per strobe.

Both pointers are byte offsets. They step by `ENTRY_BYTES` and wrap modulo `QUEUE_BYTES`, which must be a power of two. When the pointers are equal, the block tells a full queue from an empty one by a single flag that records whether the last update came from the producer side or the consumer side. It uses no extra wrap bit.

From the status and the strobes the block drives a processor-side interrupt and a host-side interrupt request. It also drives a sticky flag that reports a producer advance the block refused because the queue was full.

Top module: `cqTrack`

## Requirements
- R1: After reset both pointers are 0, the queue reads empty and not full, and overflow, cpuIrq and hostIrq are all low.
- R2: QKIND encodes the variant: 0 inbound post, 1 inbound free, 2 outbound post, 3 outbound free. Variants 0 and 3 are hardware-produced, so hwAdvance steps the head pointer. Variants 1 and 2 are software-produced, so hwAdvance steps the tail pointer. One step adds ENTRY_BYTES modulo QUEUE_BYTES.
- R3: A software write loads the selected pointer with the low log2(QUEUE_BYTES) bits of its data word. All higher bits are discarded.
- R4: Unequal pointers read as neither empty nor full. Equal pointers read as full when the last update was to the head, and as empty when the last update was to the tail.
- R5: A software write to the pointer that the hardware owns counts as an update of that pointer, exactly like a hardware step.
- R6: When the head and the tail are updated in the same cycle, both updates take effect and the last-update flag records the tail, so the queue does not read as full.
- R7: When software writes the hardware-owned pointer in the same cycle as hwAdvance, the written value is loaded and the step is dropped.
- R8: In a hardware-produced variant, hwAdvance while full leaves the head unchanged and sets overflow. Overflow stays high until reset.
- R9: In a software-produced variant, hwAdvance while empty leaves the tail unchanged.
- R10: In inbound post, cpuIrq is high for one cycle in the cycle after each hwAdvance that moved the head.
- R11: In outbound free, cpuIrq is high for exactly the first cycle in which the queue reads full.
- R12: In outbound post, hostIrq follows prefetchValid. In every other variant hostIrq stays low. cpuIrq stays low in inbound free and in outbound post.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swHeadWe | input | 1 | Software write strobe for the head pointer |
| swHeadData | input | DATA_W | Software data for the head pointer |
| swTailWe | input | 1 | Software write strobe for the tail pointer |
| swTailData | input | DATA_W | Software data for the tail pointer |
| hwAdvance | input | 1 | Hardware strobe: step the hardware-owned pointer by one entry |
| prefetchValid | input | 1 | Valid data is waiting in the prefetch stage (outbound post) |
| headPtr | output | PTR_W | Head (producer) byte offset |
| tailPtr | output | PTR_W | Tail (consumer) byte offset |
| qEmpty | output | 1 | Queue reads empty |
| qFull | output | 1 | Queue reads full |
| overflow | output | 1 | Sticky flag: a producer advance was refused because the queue was full |
| cpuIrq | output | 1 | Processor interrupt request |
| hostIrq | output | 1 | Host interrupt request |

## Verification
A hardware step and a software write can land in the same cycle. The two can target opposite pointers, which tests the tie rule for the last-update flag, or the same pointer, which tests that the load wins. The bench drives both strobes in one cycle on three variants at once. One of these cases pairs a tail write with a head step on a queue that would otherwise become full. For each case the bench predicts both pointer values and the full/empty status from the requirements. A scoreboard compares them with the outputs one clock later.

// File: rtl/cqPkg.sv
package cqPkg;

  localparam int unsigned QK_IN_POST  = 0;
  localparam int unsigned QK_IN_FREE  = 1;
  localparam int unsigned QK_OUT_POST = 2;
  localparam int unsigned QK_OUT_FREE = 3;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic loadHead;
    logic bumpHead;
    logic loadTail;
    logic bumpTail;
    logic markProd;
    logic markCons;
  } cqStrobe_t;

  function automatic bit isHwProducer(input int unsigned kind);
    return (kind == QK_IN_POST) || (kind == QK_OUT_FREE);
  endfunction

endpackage

// File: rtl/cqData.sv
module cqData
  import cqPkg::*;
#(
  parameter int unsigned QUEUE_BYTES = 64,
  parameter int unsigned ENTRY_BYTES = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned PTR_W       = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  cqStrobe_t         strobe,
  input  logic [DATA_W-1:0] swHeadData,
  input  logic [DATA_W-1:0] swTailData,
  output logic [PTR_W-1:0]  headPtr,
  output logic [PTR_W-1:0]  tailPtr,
  output logic              qEmpty,
  output logic              qFull
);

  localparam logic [PTR_W-1:0] STEP = PTR_W'(ENTRY_BYTES % QUEUE_BYTES);

  logic [PTR_W-1:0] headQ, tailQ, headNext, tailNext;
  logic             lastProdQ;
  logic             ptrsEqual;
  logic             unusedHigh;

  assign unusedHigh = ^{swHeadData, swTailData};

  always_comb begin
    headNext = headQ;
    if (strobe.loadHead)      headNext = swHeadData[PTR_W-1:0];
    else if (strobe.bumpHead) headNext = headQ + STEP;
    tailNext = tailQ;
    if (strobe.loadTail)      tailNext = swTailData[PTR_W-1:0];
    else if (strobe.bumpTail) tailNext = tailQ + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ     <= '0;
      tailQ     <= '0;
      lastProdQ <= 1'b0;
    end else begin
      headQ <= headNext;
      tailQ <= tailNext;
      if (strobe.markCons)      lastProdQ <= 1'b0;
      else if (strobe.markProd) lastProdQ <= 1'b1;
    end
  end

  assign ptrsEqual = (headQ == tailQ);
  assign qFull     = ptrsEqual & lastProdQ;
  assign qEmpty    = ptrsEqual & ~lastProdQ;
  assign headPtr   = headQ;
  assign tailPtr   = tailQ;

  AST_TIE_NOT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.markProd && strobe.markCons) |=> !qFull); // R6
  AST_FULL_FROM_HEAD: assert property (@(posedge clk) disable iff (!rstN)
    (!qFull && !strobe.markProd) |=> !qFull); // R4

endmodule

// File: rtl/cqCtrl.sv
module cqCtrl
  import cqPkg::*;
#(
  parameter int unsigned QKIND = QK_IN_POST
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      swHeadWe,
  input  logic      swTailWe,
  input  logic      hwAdvance,
  input  logic      prefetchValid,
  input  logic      qEmpty,
  input  logic      qFull,
  output cqStrobe_t strobe,
  output logic      overflow,
  output logic      cpuIrq,
  output logic      hostIrq
);

  localparam bit HW_PROD = isHwProducer(QKIND);

  logic ovfHit;
  logic advTaken;
  logic overflowQ;
  logic unusedStatus;

  assign unusedStatus = ^{qEmpty, qFull};

  generate
    if (HW_PROD) begin : gHwProd
      always_comb begin
        strobe          = '0;
        strobe.loadHead = swHeadWe;
        strobe.bumpHead = hwAdvance & ~swHeadWe & ~qFull;
        strobe.loadTail = swTailWe;
        strobe.markProd = swHeadWe | strobe.bumpHead;
        strobe.markCons = swTailWe;
      end
      assign ovfHit   = hwAdvance & ~swHeadWe & qFull;
      assign advTaken = strobe.bumpHead;

      AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
        (qFull && hwAdvance && !swHeadWe && !swTailWe) |=> (qFull && overflow)); // R8
    end else begin : gSwProd
      always_comb begin
        strobe          = '0;
        strobe.loadTail = swTailWe;
        strobe.bumpTail = hwAdvance & ~swTailWe & ~qEmpty;
        strobe.loadHead = swHeadWe;
        strobe.markProd = swHeadWe;
        strobe.markCons = swTailWe | strobe.bumpTail;
      end
      assign ovfHit   = 1'b0;
      assign advTaken = strobe.bumpTail;

      AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
        (qEmpty && hwAdvance && !swHeadWe && !swTailWe) |=> qEmpty); // R9
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) overflowQ <= 1'b0;
    else if (ovfHit) overflowQ <= 1'b1;
  end
  assign overflow = overflowQ;

  generate
    if (QKIND == QK_IN_POST) begin : gIrqWrite
      logic pulseQ;
      always_ff @(posedge clk) begin
        if (!rstN) pulseQ <= 1'b0;
        else       pulseQ <= advTaken;
      end
      assign cpuIrq = pulseQ;
    end else if (QKIND == QK_OUT_FREE) begin : gIrqFull
      logic fullSeenQ;
      logic unusedAdv;
      assign unusedAdv = advTaken;
      always_ff @(posedge clk) begin
        if (!rstN) fullSeenQ <= 1'b0;
        else       fullSeenQ <= qFull;
      end
      assign cpuIrq = qFull & ~fullSeenQ;

      AST_FULL_IRQ_ONCE: assert property (@(posedge clk) disable iff (!rstN)
        cpuIrq |=> !cpuIrq); // R11
      AST_FULL_IRQ_STATUS: assert property (@(posedge clk) disable iff (!rstN)
        cpuIrq |-> qFull); // R11
    end else begin : gIrqNone
      logic unusedAdv;
      assign unusedAdv = advTaken;
      assign cpuIrq    = 1'b0;
    end
  endgenerate

  assign hostIrq = (QKIND == QK_OUT_POST) ? prefetchValid : 1'b0;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflowQ |=> overflowQ); // R8

endmodule

// File: rtl/cqTrack.sv
module cqTrack
  import cqPkg::*;
#(
  parameter int unsigned QKIND       = QK_IN_POST,
  parameter int unsigned QUEUE_BYTES = 64,
  parameter int unsigned ENTRY_BYTES = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned PTR_W       = $clog2(QUEUE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swHeadWe,
  input  logic [DATA_W-1:0] swHeadData,
  input  logic              swTailWe,
  input  logic [DATA_W-1:0] swTailData,
  input  logic              hwAdvance,
  input  logic              prefetchValid,
  output logic [PTR_W-1:0]  headPtr,
  output logic [PTR_W-1:0]  tailPtr,
  output logic              qEmpty,
  output logic              qFull,
  output logic              overflow,
  output logic              cpuIrq,
  output logic              hostIrq
);

  cqStrobe_t strobe;

  cqCtrl #(.QKIND(QKIND)) uCtrl (
    .clk(clk), .rstN(rstN), .swHeadWe(swHeadWe), .swTailWe(swTailWe),
    .hwAdvance(hwAdvance), .prefetchValid(prefetchValid),
    .qEmpty(qEmpty), .qFull(qFull), .strobe(strobe),
    .overflow(overflow), .cpuIrq(cpuIrq), .hostIrq(hostIrq)
  );

  cqData #(
    .QUEUE_BYTES(QUEUE_BYTES), .ENTRY_BYTES(ENTRY_BYTES),
    .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .swHeadData(swHeadData), .swTailData(swTailData),
    .headPtr(headPtr), .tailPtr(tailPtr), .qEmpty(qEmpty), .qFull(qFull)
  );

  AST_EQUAL_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (headPtr != tailPtr) |-> (!qEmpty && !qFull)); // R4

endmodule

// File: tb/cqTrack_test.sv
`timescale 1ns/1ps
module cqTrack_test;

  localparam int PW = 6;
  localparam int NI = 3;
  localparam int KIND_OF [NI] = '{0, 3, 2};

  typedef struct packed {
    logic [PW-1:0] h;
    logic [PW-1:0] t;
    logic e, f, o, c, x;
  } obs_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hWe = 1'b0, tWe = 1'b0, adv = 1'b0, pv = 1'b0;
  logic [31:0] hD = '0, tD = '0;

  logic [PW-1:0] hp [NI];
  logic [PW-1:0] tp [NI];
  logic emp [NI], ful [NI], ovf [NI], cirq [NI], hirq [NI];

  always #5 clk = ~clk;

  cqTrack #(.QKIND(0)) uut (.clk(clk), .rstN(rstN), .swHeadWe(hWe), .swHeadData(hD),
    .swTailWe(tWe), .swTailData(tD), .hwAdvance(adv), .prefetchValid(pv),
    .headPtr(hp[0]), .tailPtr(tp[0]), .qEmpty(emp[0]), .qFull(ful[0]),
    .overflow(ovf[0]), .cpuIrq(cirq[0]), .hostIrq(hirq[0]));
  cqTrack #(.QKIND(3)) uutF (.clk(clk), .rstN(rstN), .swHeadWe(hWe), .swHeadData(hD),
    .swTailWe(tWe), .swTailData(tD), .hwAdvance(adv), .prefetchValid(pv),
    .headPtr(hp[1]), .tailPtr(tp[1]), .qEmpty(emp[1]), .qFull(ful[1]),
    .overflow(ovf[1]), .cpuIrq(cirq[1]), .hostIrq(hirq[1]));
  cqTrack #(.QKIND(2)) uutO (.clk(clk), .rstN(rstN), .swHeadWe(hWe), .swHeadData(hD),
    .swTailWe(tWe), .swTailData(tD), .hwAdvance(adv), .prefetchValid(pv),
    .headPtr(hp[2]), .tailPtr(tp[2]), .qEmpty(emp[2]), .qFull(ful[2]),
    .overflow(ovf[2]), .cpuIrq(cirq[2]), .hostIrq(hirq[2]));

  int total = 0;
  int bad = 0;
  obs_t expQ [$];
  string tagQ [$];

  logic [PW-1:0] mH [NI];
  logic [PW-1:0] mT [NI];
  bit mL [NI], mO [NI];

  function automatic obs_t actual(input int i);
    obs_t a;
    a.h = hp[i]; a.t = tp[i]; a.e = emp[i]; a.f = ful[i];
    a.o = ovf[i]; a.c = cirq[i]; a.x = hirq[i];
    return a;
  endfunction

  task automatic check(input string tag, input int i, input obs_t act, input obs_t exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s inst%0d: act h=%0d t=%0d e=%b f=%b o=%b c=%b x=%b exp h=%0d t=%0d e=%b f=%b o=%b c=%b x=%b",
        tag, i, act.h, act.t, act.e, act.f, act.o, act.c, act.x,
        exp.h, exp.t, exp.e, exp.f, exp.o, exp.c, exp.x);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the predicted outputs.
  task automatic step(input bit a, input bit hw, input logic [31:0] hd,
                      input bit tw, input logic [31:0] td, input bit p, input string tag);
    @(negedge clk);
    adv = a; hWe = hw; hD = hd; tWe = tw; tD = td; pv = p;
    for (int i = 0; i < NI; i++) begin
      obs_t e;
      bit hwProd, oldFull, oldEmpty, ok, hu, tu, newFull;
      logic [PW-1:0] nh, nt;
      hwProd   = (KIND_OF[i] == 0) || (KIND_OF[i] == 3);
      oldFull  = (mH[i] == mT[i]) && mL[i];
      oldEmpty = (mH[i] == mT[i]) && !mL[i];
      nh = hw ? hd[PW-1:0] : mH[i];
      nt = tw ? td[PW-1:0] : mT[i];
      hu = hw; tu = tw; ok = 0;
      if (hwProd) begin
        ok = a && !hw && !oldFull;
        if (ok) begin nh = mH[i] + 6'd4; hu = 1; end
        if (a && !hw && oldFull) mO[i] = 1;
      end else begin
        ok = a && !tw && !oldEmpty;
        if (ok) begin nt = mT[i] + 6'd4; tu = 1; end
      end
      if (tu) mL[i] = 0; else if (hu) mL[i] = 1;
      mH[i] = nh; mT[i] = nt;
      newFull = (nh == nt) && mL[i];
      e.h = nh; e.t = nt; e.f = newFull; e.e = (nh == nt) && !mL[i];
      e.o = mO[i];
      e.c = (KIND_OF[i] == 0) ? ok : (KIND_OF[i] == 3) ? (newFull && !oldFull) : 1'b0;
      e.x = (KIND_OF[i] == 2) ? p : 1'b0;
      expQ.push_back(e);
      tagQ.push_back(tag);
    end
    @(posedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: pop predictions and compare after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      for (int i = 0; i < NI; i++) begin
        if (expQ.size() > 0) begin
          obs_t e;
          string tg;
          e = expQ.pop_front();
          tg = tagQ.pop_front();
          check(tg, i, actual(i), e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NI; i++) begin mH[i] = 0; mT[i] = 0; mL[i] = 0; mO[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      obs_t z;
      z = '0; z.e = 1'b1;
      check("R1 reset", i, actual(i), z);
    end
    rstN = 1'b1;
    // R2 R10 R11 R9: sixteen steps fill hardware-produced queues; empty outbound post ignores them
    for (int k = 0; k < 16; k++) step(1, 0, 0, 0, 0, 0, "R2 R9 R10 R11 fill");
    idle("R11 pulse ends");
    // R8: step while full is refused and overflow sticks
    step(1, 0, 0, 0, 0, 0, "R8 overflow");
    idle("R8 sticky");
    // R4: consumer write breaks equality
    step(0, 0, 0, 1, 32'h8, 0, "R4 tail write");
    // R3 R5: head write masked; head write on hardware-owned pointer counts as producer
    step(0, 1, 32'h1234_5678, 0, 0, 0, "R3 R5 masked head");
    step(0, 1, 32'hFFFF_FF08, 0, 0, 0, "R5 head write equal -> full");
    // R6: tail write with hardware head step in one cycle
    step(0, 0, 0, 1, 32'h20, 0, "R6 setup");
    step(0, 1, 32'h1C, 0, 0, 0, "R6 setup head");
    step(1, 0, 0, 1, 32'h20, 0, "R6 tie to consumer");
    step(1, 1, 32'h10, 1, 32'h10, 0, "R6 both written");
    // R7: write wins over step on the same pointer
    step(1, 1, 32'h30, 0, 0, 0, "R7 head write wins");
    step(1, 0, 0, 1, 32'h3C, 0, "R7 tail write wins");
    // R12: prefetch flag to host irq
    step(0, 0, 0, 0, 0, 1, "R12 prefetch high");
    step(0, 0, 0, 0, 0, 0, "R12 prefetch low");
    // R2 R9: outbound post drains by hardware, then refuses when empty
    step(0, 1, 32'h08, 1, 32'h00, 1, "R2 reload");
    step(1, 0, 0, 0, 0, 1, "R2 drain");
    step(1, 0, 0, 0, 0, 0, "R2 drain");
    step(1, 0, 0, 0, 0, 0, "R9 empty refuse");
    // R10 R11: refill hardware-produced queues to full with wrap
    for (int k = 0; k < 17; k++) step(1, 0, 0, 0, 0, 0, "R2 R10 R11 wrap");
    idle("R1 end idle");
    repeat (3) @(posedge clk);
    #3;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule